// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a 16-bit timer. The timer's free-running count and its wrap pulse arrive as inputs. Software reaches the channel over an 8-bit register bus. In capture mode the channel watches its pin through a synchronizer and stores the count when a chosen edge arrives. In compare mode it drives its pin whenever the count equals the stored channel value. A wrap of the counter can also toggle the pin, which gives a simple PWM. A maximum-duty control holds that PWM output at 100%, but it only takes effect at a period boundary.

The 16-bit channel value is reached as two bytes, and the order of the byte accesses forms an interlock. In capture mode, reading the upper byte holds off new captures until the lower byte has been read, so the two bytes always belong to one sample. In compare mode, writing the upper byte holds off matches until the lower byte has been written, so a half-updated value never fires. Each capture or match sets an event flag. Software clears the flag in two steps, and the flag can raise an interrupt line.

Top module: `tmr_chan`

## Requirements
- R1: After a synchronous reset, pin_o and irq_o are 0 and the control byte reads 0x00.
- R2: There are three registers. Address 0 is control: bits [1:0] mode, [3:2] action select, bit 4 toggle-on-wrap, bit 5 max-duty, bit 6 interrupt enable, bit 7 event flag. Address 1 is the value's upper byte and address 2 its lower byte. Read data appears on rdata_o in the cycle after the read strobe.
- R3: Mode 00 is capture. A pin change set up before clock edge k is captured at edge k+2, and the stored value is the cnt_i present at that edge.
- R4: In capture mode the action select chooses the edge: 01 rising, 10 falling, 11 both, 00 none. An edge that is not selected leaves the value unchanged.
- R5: In capture mode, a read of the upper byte blocks captures until the lower byte is read. Both bytes then return the sample that was held, and captures resume after the lower-byte read.
- R6: Modes 01, 10 and 11 are compare modes. When cnt_i equals the value, pin_o changes at that edge according to the action select: 01 toggle, 10 drive 0, 11 drive 1, 00 no change.
- R7: A write of the upper byte blocks compare matches until the lower byte is written.
- R8: With toggle-on-wrap set, pin_o toggles on each ovf_i in compare mode. In capture mode the bit has no effect, and pin_o holds its value.
- R9: When a wrap and a match fall in the same cycle with toggle-on-wrap set, the wrap action wins.
- R10: The max-duty bit is taken over only at an ovf_i. While it is in effect with toggle-on-wrap set, pin_o is held at 1. Setting or clearing the bit changes nothing until the next wrap.
- R11: Each capture or match sets the flag. The flag clears only when control is read while the flag is 1 and control is then written with bit 7 = 0. irq_o follows flag AND enable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 2 | Register select |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| cnt_i | input | CNT_W | Timer count |
| ovf_i | input | 1 | Counter wrap pulse |
| pin_i | input | 1 | Capture pin (asynchronous) |
| pin_o | output | 1 | Compare/PWM pin |
| irq_o | output | 1 | Event interrupt |

## Verification
Results fall due at different edges. Read data is due one edge after the strobe, a capture two edges after the edge that first sees the pin, and a pin_o update at the edge that samples the match or wrap. The flag and irq_o are due at that same edge. The bench drives all inputs at falling edges and samples all outputs at falling edges. It moves the count 3 ns after each rising edge, so every expected value is tied to a known edge. A bench model of the pin, built from the requirements, is compared against pin_o once per cycle during the compare phases.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_VHI  = 2'd1;
  localparam logic [1:0] ADDR_VLO  = 2'd2;
  localparam logic [1:0] MODE_CAPTURE = 2'b00;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } cmp_act_e;
endpackage

// File: rtl/tmr_chan_sync.sv
module tmr_chan_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      last <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], pin};
      last <= sh[STAGES-1];
    end
  end

  assign rise = sh[STAGES-1] & ~last;
  assign fall = ~sh[STAGES-1] & last;
endmodule

// File: rtl/tmr_chan_valreg.sv
module tmr_chan_valreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_mode,
  input  logic         cap_evt,
  input  logic [W-1:0] cnt,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic         rd_hi,
  input  logic         rd_lo,
  input  logic [7:0]   wdata,
  output logic [W-1:0] val,
  output logic         cap_lock,
  output logic         cmp_lock,
  output logic         cap_done
);
  localparam int HI_W = W - 8;

  // a capture is refused while a paired read is open or starting
  assign cap_done = cap_mode && cap_evt && !cap_lock && !rd_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      val      <= '0;
      cap_lock <= 1'b0;
      cmp_lock <= 1'b0;
    end else begin
      if (cap_done) begin
        val <= cnt;
      end else begin
        if (wr_hi) val[W-1:8] <= wdata[HI_W-1:0];
        if (wr_lo) val[7:0]   <= wdata;
      end
      if (rd_lo)                 cap_lock <= 1'b0;
      else if (rd_hi && cap_mode) cap_lock <= 1'b1;
      if (wr_lo)      cmp_lock <= 1'b0;
      else if (wr_hi) cmp_lock <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_chan_outctl.sv
module tmr_chan_outctl
  import tmr_chan_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cmp_mode,
  input  cmp_act_e act,
  input  logic     tov,
  input  logic     maxd_req,
  input  logic     ovf,
  input  logic     hit,
  output logic     pin,
  output logic     maxd_eff
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin      <= 1'b0;
      maxd_eff <= 1'b0;
    end else begin
      if (ovf) maxd_eff <= maxd_req;
      if (cmp_mode) begin
        if (tov && ovf) begin
          pin <= maxd_req ? 1'b1 : ~pin;
        end else if (tov && maxd_eff) begin
          pin <= 1'b1;
        end else if (hit) begin
          unique case (act)
            ACT_TOGGLE: pin <= ~pin;
            ACT_CLEAR:  pin <= 1'b0;
            ACT_SET:    pin <= 1'b1;
            default:    pin <= pin;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       addr_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ovf_i,
  input  logic             pin_i,
  output logic             pin_o,
  output logic             irq_o
);
  logic [1:0] mode_q, sel_q;
  logic tov_q, maxd_q, ie_q, flag_q, arm_q;
  logic [CNT_W-1:0] val;
  logic cap_lock, cmp_lock, cap_done, rise, fall, maxd_eff;

  logic wr_ctrl, rd_ctrl, wr_hi, wr_lo, rd_hi, rd_lo;
  assign wr_ctrl = wr_en_i && addr_i == ADDR_CTRL;
  assign rd_ctrl = rd_en_i && addr_i == ADDR_CTRL;
  assign wr_hi   = wr_en_i && addr_i == ADDR_VHI;
  assign wr_lo   = wr_en_i && addr_i == ADDR_VLO;
  assign rd_hi   = rd_en_i && addr_i == ADDR_VHI;
  assign rd_lo   = rd_en_i && addr_i == ADDR_VLO;

  logic cap_mode, cap_evt, hit;
  assign cap_mode = mode_q == MODE_CAPTURE;
  assign cap_evt  = (sel_q[0] & rise) | (sel_q[1] & fall);
  assign hit      = !cap_mode && !cmp_lock && cnt_i == val;

  tmr_chan_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(pin_i), .rise(rise), .fall(fall)
  );

  tmr_chan_valreg #(.W(CNT_W)) u_val (
    .clk(clk), .rst(rst), .cap_mode(cap_mode), .cap_evt(cap_evt),
    .cnt(cnt_i), .wr_hi(wr_hi), .wr_lo(wr_lo), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .wdata(wdata_i), .val(val), .cap_lock(cap_lock), .cmp_lock(cmp_lock),
    .cap_done(cap_done)
  );

  tmr_chan_outctl u_out (
    .clk(clk), .rst(rst), .cmp_mode(!cap_mode), .act(cmp_act_e'(sel_q)),
    .tov(tov_q), .maxd_req(maxd_q), .ovf(ovf_i), .hit(hit),
    .pin(pin_o), .maxd_eff(maxd_eff)
  );

  logic flag_d, ie_d;
  always_comb begin
    flag_d = flag_q;
    if (wr_ctrl && arm_q && !wdata_i[7]) flag_d = 1'b0;
    if (cap_done || hit)                 flag_d = 1'b1;
    ie_d = wr_ctrl ? wdata_i[6] : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_CAPTURE;
      sel_q   <= 2'b00;
      tov_q   <= 1'b0;
      maxd_q  <= 1'b0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      arm_q   <= 1'b0;
      irq_o   <= 1'b0;
      rdata_o <= 8'h00;
    end else begin
      if (wr_ctrl) begin
        mode_q <= wdata_i[1:0];
        sel_q  <= wdata_i[3:2];
        tov_q  <= wdata_i[4];
        maxd_q <= wdata_i[5];
        ie_q   <= wdata_i[6];
      end
      flag_q <= flag_d;
      if (wr_ctrl)               arm_q <= 1'b0;
      else if (rd_ctrl && flag_q) arm_q <= 1'b1;
      irq_o <= flag_d && ie_d;
      if (rd_en_i) begin
        unique case (addr_i)
          ADDR_CTRL: rdata_o <= {flag_q, ie_q, maxd_q, tov_q, sel_q, mode_q};
          ADDR_VHI:  rdata_o <= 8'(val >> 8);
          ADDR_VLO:  rdata_o <= val[7:0];
          default:   rdata_o <= 8'h00;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cap_mode,
  input logic             tov,
  input logic             maxd_req,
  input logic             maxd_eff,
  input logic             ovf,
  input logic             pin,
  input logic             cap_lock,
  input logic             cmp_lock,
  input logic [CNT_W-1:0] val,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [7:0]       wdata,
  input logic             flag
);
  p_cap_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (cap_lock && !wr_en) |=> $stable(val));

  p_cap_pin_r8: assert property (@(posedge clk) disable iff (rst)
    cap_mode |=> $stable(pin));

  p_ovf_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (!cap_mode && tov && ovf && !maxd_req) |=> (pin != $past(pin)));

  p_cmp_lock_r7: assert property (@(posedge clk) disable iff (rst)
    (!cap_mode && cmp_lock && !(tov && (ovf || maxd_eff))) |=> $stable(pin));

  p_maxd_force_r10: assert property (@(posedge clk) disable iff (rst)
    (!cap_mode && tov && maxd_eff && !ovf) |=> pin);

  p_flag_clr_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(wr_en && addr == 2'd0 && !wdata[7]));
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cap_mode(cap_mode), .tov(tov_q), .maxd_req(maxd_q),
  .maxd_eff(maxd_eff), .ovf(ovf_i), .pin(pin_o), .cap_lock(cap_lock),
  .cmp_lock(cmp_lock), .val(val), .wr_en(wr_en_i), .addr(addr_i),
  .wdata(wdata_i), .flag(flag_q)
);

// File: tb/tmr_chan_bench.sv
`timescale 1ns/1ps
module tmr_chan_bench;
  logic clk = 0, rst = 1;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0, pin_in = 0, ovf = 0;
  logic [7:0] wdata = 0, rdata;
  logic [15:0] cnt = 0;
  logic pin_out, irq;
  int per = 60000;
  bit run = 0, chk_en = 0, done = 0;
  int n_vec = 0, n_bad = 0;

  // shadow of software-visible state and pin reference model
  logic [1:0] m_mode = 0, m_sel = 0;
  logic m_tov = 0, m_maxd = 0, m_lock = 0, m_pin = 0, m_meff = 0;
  logic [15:0] m_val = 0;

  always #10 clk = ~clk;

  tmr_chan u_tmr_chan (
    .clk(clk), .rst(rst), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .cnt_i(cnt), .ovf_i(ovf),
    .pin_i(pin_in), .pin_o(pin_out), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counter moves 3 ns after each rising edge
  always @(posedge clk) begin
    #3;
    if (run) begin
      cnt = (int'(cnt) + 1 >= per) ? 16'd0 : cnt + 16'd1;
      ovf = (cnt == 0);
    end else ovf = 0;
  end

  // pin model per R6, R8, R9, R10
  always @(posedge clk) begin
    logic hit_m, p, e;
    if (rst) begin
      m_pin = 0; m_meff = 0;
    end else begin
      hit_m = (m_mode != 0) && !m_lock && (cnt == m_val);
      p = m_pin; e = m_meff;
      if (ovf) e = m_maxd;
      if (m_mode != 0) begin
        if (m_tov && ovf) p = m_maxd ? 1'b1 : ~m_pin;
        else if (m_tov && m_meff) p = 1'b1;
        else if (hit_m) begin
          if (m_sel == 1) p = ~m_pin;
          else if (m_sel == 2) p = 1'b0;
          else if (m_sel == 3) p = 1'b1;
        end
      end
      m_pin = p; m_meff = e;
    end
  end

  always @(negedge clk)
    if (chk_en) chk("R6 R8 R9 R10 pin model", pin_out, m_pin);

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    case (a)
      2'd0: begin m_mode = d[1:0]; m_sel = d[3:2]; m_tov = d[4]; m_maxd = d[5]; end
      2'd1: begin m_val[15:8] = d; m_lock = 1; end
      2'd2: begin m_val[7:0] = d; m_lock = 0; end
      default: ;
    endcase
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  function automatic logic [7:0] ctl(input int mode, input int sel, input int tov,
                                     input int maxd, input int ie, input int fl);
    return {fl[0], ie[0], maxd[0], tov[0], sel[1:0], mode[1:0]};
  endfunction

  task automatic rd_val(output logic [15:0] v);
    logic [7:0] h, l;
    bus_rd(2'd1, h); bus_rd(2'd2, l); v = {h, l};
  endtask

  // set pin, return the count that the capture edge will see (R3)
  task automatic drive_pin(input logic lvl, output logic [15:0] expv);
    @(negedge clk); pin_in = lvl;
    expv = 16'((int'(cnt) + 2) % per);
    repeat (5) @(negedge clk);
  endtask

  task automatic wait_cnt(input int v);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (cnt == v) break;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic [15:0] v, e1, e2, old;
    logic p1, p2;
    int seed;
    seed = $urandom(32'h5eed);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 pin_o reset", pin_out, 0);
    chk("R1 irq_o reset", irq, 0);
    bus_rd(2'd0, d);
    chk("R1 R2 ctrl reset", d, 0);
    chk_en = 1;
    run = 1;

    // capture timing (R3), flag/irq (R11)
    bus_wr(2'd0, ctl(0, 1, 0, 0, 1, 1));
    drive_pin(1, e1);
    rd_val(v);
    chk("R3 capture latency", v, e1);
    chk("R11 irq after capture", irq, 1);

    // interlock (R5)
    bus_rd(2'd1, d);
    chk("R5 hi byte", d, e1[15:8]);
    drive_pin(0, e2);
    drive_pin(1, e2);
    bus_rd(2'd2, d);
    chk("R5 lo byte held", d, e1[7:0]);
    rd_val(v);
    chk("R5 no capture while locked", v, e1);
    drive_pin(0, e2);
    drive_pin(1, e2);
    rd_val(v);
    chk("R5 capture resumes", v, e2);

    // edge selection (R4)
    bus_wr(2'd0, ctl(0, 2, 0, 0, 1, 1));
    drive_pin(0, e1);
    rd_val(v);
    chk("R4 falling captured", v, e1);
    drive_pin(1, e2);
    rd_val(v);
    chk("R4 rising ignored", v, e1);
    bus_wr(2'd0, ctl(0, 3, 0, 0, 1, 1));
    drive_pin(0, e1);
    rd_val(v);
    chk("R4 both edges", v, e1);
    bus_wr(2'd0, ctl(0, 0, 0, 0, 1, 1));
    drive_pin(1, e2);
    rd_val(v);
    chk("R4 none selected", v, e1);

    // flag clear protocol (R11)
    bus_wr(2'd0, ctl(0, 0, 0, 0, 1, 0));
    chk("R11 clear needs prior read", irq, 1);
    bus_rd(2'd0, d);
    chk("R11 flag read", d[7], 1);
    bus_wr(2'd0, ctl(0, 0, 0, 0, 1, 0));
    chk("R11 irq cleared", irq, 0);
    bus_rd(2'd0, d);
    chk("R11 flag cleared", d[7], 0);

    // toggle-on-wrap in capture mode (R8)
    per = 24;
    p1 = pin_out;
    bus_wr(2'd0, ctl(0, 0, 1, 1, 1, 1));
    repeat (60) @(negedge clk);
    chk("R8 no toggle in capture", pin_out, p1);
    chk("R8 no event in capture", irq, 0);

    // compare actions (R6)
    bus_wr(2'd1, 8'd0); bus_wr(2'd2, 8'd5);
    bus_wr(2'd0, ctl(1, 3, 0, 0, 1, 1));
    wait_cnt(8);
    chk("R6 set on match", pin_out, 1);
    bus_wr(2'd0, ctl(1, 2, 0, 0, 1, 1));
    wait_cnt(8);
    chk("R6 clear on match", pin_out, 0);
    bus_wr(2'd0, ctl(1, 1, 0, 0, 1, 1));
    wait_cnt(8); p1 = pin_out;
    wait_cnt(8); p2 = pin_out;
    chk("R6 toggle on match", p2, !p1);

    // compare interlock (R7)
    bus_wr(2'd0, ctl(1, 2, 0, 0, 1, 1));
    wait_cnt(8);
    bus_wr(2'd1, 8'd0);
    bus_wr(2'd0, ctl(2, 3, 0, 0, 1, 1));
    repeat (50) @(negedge clk);
    chk("R7 match blocked", pin_out, 0);
    bus_wr(2'd2, 8'd5);
    repeat (30) @(negedge clk);
    chk("R7 match after lo write", pin_out, 1);

    // wrap wins over coincident match (R9)
    bus_wr(2'd1, 8'd0); bus_wr(2'd2, 8'd0);
    bus_wr(2'd0, ctl(3, 2, 1, 0, 1, 1));
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (ovf && pin_out == 0) begin
        @(negedge clk);
        chk("R9 wrap beats clear", pin_out, 1);
        break;
      end
    end

    // max-duty latency (R10)
    bus_wr(2'd1, 8'd0); bus_wr(2'd2, 8'd12);
    bus_wr(2'd0, ctl(1, 1, 1, 0, 1, 1));
    wait_cnt(3);
    bus_wr(2'd0, ctl(1, 1, 1, 1, 1, 1));
    wait_cnt(10); p1 = pin_out;
    wait_cnt(14);
    chk("R10 not forced in same period", pin_out, !p1);
    wait_cnt(14);
    chk("R10 forced next period", pin_out, 1);
    wait_cnt(3);
    bus_wr(2'd0, ctl(1, 1, 1, 0, 1, 1));
    wait_cnt(14);
    chk("R10 held until boundary", pin_out, 1);
    wait_cnt(10); p1 = pin_out;
    wait_cnt(14);
    chk("R10 released after boundary", pin_out, !p1);

    // constrained random compare/PWM traffic against the model
    for (int it = 0; it < 40; it++) begin
      per = 8 + int'($urandom % 33);
      v = 16'($urandom % per);
      bus_wr(2'd1, v[15:8]);
      repeat (int'($urandom % 30)) @(negedge clk);
      bus_wr(2'd2, v[7:0]);
      bus_wr(2'd0, ctl(1 + int'($urandom % 3), int'($urandom % 4),
                       int'($urandom % 2), int'($urandom % 2), 1, 1));
      repeat (20 + int'($urandom % 100)) @(negedge clk);
    end

    done = 1;
    chk_en = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule